// File: doc/BRIEF.md
# Readout Link Frame Encoder

This block stands in for a dedicated serial-link transmitter chip on a readout path. Once per word-clock cycle (the 40 MHz bunch-crossing clock) it takes one 24-bit readout word and a data-available flag. On a line clock running at three times that rate and phase-locked to it, the block cuts the word into three 8-bit slices. Each slice becomes a 20-bit line word for an external serializer. A line word holds a 4-bit control code above a 16-bit DC-balanced payload, built from each slice bit and its complement.

After reset, a channel sends a fixed training frame for a set number of line cycles and then raises its locked flag. From then on it sends either the three data slices of a word or, when the data-available flag was low at the word edge, three idle frames carrying zeros. Two identical channels share the two clocks: one carries event data and one carries region-of-interest data. Each channel has its own reset, word, flag, frame and locked signals.

Top module: `rdlink_frame_enc`

## Requirements
- R1: A line word is {control[19:16], payload[15:0]}. For a slice s, payload bit 2i+1 equals s[i] and payload bit 2i equals the inverse of s[i], so every payload has exactly eight ones.
- R2: A word captured at a word-clock edge appears as three frames on the three line-clock edges that follow that edge. Slice [23:16] comes first with control 4'b1010, then [15:8] and [7:0], each with control 4'b0011.
- R3: When the flag was low at the word edge, all three frames of that triplet are idle frames: control 4'b0101 and the payload of a zero slice (16'h5555).
- R4: After reset, exactly LOCK_CYCLES (64) training frames follow: control 4'b1100 with the payload of slice 8'h0F (16'h55AA). Locked rises on the same line edge that produces the last training frame and stays high until the next reset.
- R5: Word and flag are sampled only at the word-clock edge. Changes between edges have no effect, and a triplet never mixes data and idle frames.
- R6: A triplet whose start edge came before locked was high is sent as idle frames, including the slices that fall after lock.
- R7: Synchronous active-high reset clears the frame output to zero and locked to low on the next line edge. Reset must be held across at least one word-clock edge.
- R8: The two channels are independent: resetting one leaves the other's frames and locked flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_word | input | 1 | Word clock, one edge per readout word |
| clk_line | input | 1 | Line clock, three times the word rate, phase-locked |
| daq_rst | input | 1 | Synchronous reset of the event-data channel |
| daq_word | input | 24 | Event-data word |
| daq_dav | input | 1 | Event-data available flag |
| daq_frame | output | 20 | Event-data line word to serializer |
| daq_locked | output | 1 | Event-data channel has finished training |
| roi_rst | input | 1 | Synchronous reset of the region-of-interest channel |
| roi_word | input | 24 | Region-of-interest word |
| roi_dav | input | 1 | Region-of-interest data available flag |
| roi_frame | output | 20 | Region-of-interest line word to serializer |
| roi_locked | output | 1 | Region-of-interest channel has finished training |

## Verification
The end of training and the start of a slice triplet can land on the same line edge, or lock can come in the middle of a triplet. The bench releases the region-of-interest reset at each of the three slice phases, so lock completes once at every phase. Each time it checks that the training count is exact, that locked rises with the last training frame, and that a triplet which began before lock is sent only as idle frames. Words and flags change on every line cycle so that only the values sampled at word edges count, and all byte values pass through each slice position.

// File: rtl/rdlink_pkg.sv
package rdlink_pkg;
  localparam int CTL_W = 4;

  typedef enum logic [CTL_W-1:0] {
    CTL_NONE  = 4'b0000,
    CTL_TRAIN = 4'b1100,
    CTL_IDLE  = 4'b0101,
    CTL_FIRST = 4'b1010,
    CTL_NEXT  = 4'b0011
  } ctl_e;
endpackage

// File: rtl/rdlink_word_capture.sv
module rdlink_word_capture #(
  parameter int WORD_W = 24
) (
  input  logic              clk_word,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              dav_i,
  output logic [WORD_W-1:0] word_o,
  output logic              dav_o,
  output logic              tgl_o
);
  // word and flag registered at every word edge; toggle marks a fresh word
  always_ff @(posedge clk_word) begin
    word_o <= word_i;
    dav_o  <= dav_i;
    if (rst) tgl_o <= 1'b0;
    else     tgl_o <= ~tgl_o;
  end
endmodule

// File: rtl/rdlink_balance_enc.sv
module rdlink_balance_enc #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0]   slice_i,
  output logic [2*SLICE_W-1:0] code_o
);
  // each data bit is paired with its inverse: payload is always DC balanced
  for (genvar i = 0; i < SLICE_W; i++) begin : g_pair
    assign code_o[2*i+1] = slice_i[i];
    assign code_o[2*i]   = ~slice_i[i];
  end
endmodule

// File: rtl/rdlink_line_enc.sv
module rdlink_line_enc
  import rdlink_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SLICE_W     = 8,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                       clk_line,
  input  logic                       rst,
  input  logic [WORD_W-1:0]          word_i,
  input  logic                       dav_i,
  input  logic                       tgl_i,
  output logic [CTL_W+2*SLICE_W-1:0] frame_o,
  output logic                       locked_o
);
  localparam int NSLICE  = WORD_W / SLICE_W;
  localparam int PH_W    = (NSLICE > 1) ? $clog2(NSLICE) : 1;
  localparam int LC_W    = $clog2(LOCK_CYCLES + 1);
  localparam int FRAME_W = CTL_W + 2 * SLICE_W;
  localparam logic [SLICE_W-1:0] TRAIN_SLICE = SLICE_W'((1 << (SLICE_W / 2)) - 1);

  logic [WORD_W-1:0]    hold_q;
  logic                 hdav_q;
  logic [PH_W-1:0]      phase_q;
  logic                 active_q;
  logic                 tgl_seen_q;
  logic [LC_W-1:0]      lock_cnt_q;
  logic                 locked_q;
  logic [FRAME_W-1:0]   frame_q;

  logic                 start;
  logic                 data_go;
  logic [WORD_W-1:0]    src;
  logic [SLICE_W-1:0]   sel;
  logic [SLICE_W-1:0]   enc_in;
  logic [2*SLICE_W-1:0] code;
  ctl_e                 ctl_n;

  assign start = tgl_i ^ tgl_seen_q;

  // slice select, most significant slice first
  always_comb begin
    src = start ? word_i : hold_q;
    sel = '0;
    for (int i = 0; i < NSLICE; i++) begin
      if (start ? (i == 0) : (i == int'(phase_q)))
        sel = src[(NSLICE-1-i)*SLICE_W +: SLICE_W];
    end
  end

  always_comb begin
    data_go = locked_q && ((start && dav_i) || (!start && active_q && hdav_q));
    if (!locked_q) begin
      enc_in = TRAIN_SLICE;
      ctl_n  = CTL_TRAIN;
    end else if (!data_go) begin
      enc_in = '0;
      ctl_n  = CTL_IDLE;
    end else begin
      enc_in = sel;
      ctl_n  = start ? CTL_FIRST : CTL_NEXT;
    end
  end

  rdlink_balance_enc #(.SLICE_W(SLICE_W)) u_bal (
    .slice_i (enc_in),
    .code_o  (code)
  );

  always_ff @(posedge clk_line) begin
    if (rst) begin
      hold_q     <= '0;
      hdav_q     <= 1'b0;
      phase_q    <= '0;
      active_q   <= 1'b0;
      tgl_seen_q <= 1'b0;
      lock_cnt_q <= '0;
      locked_q   <= 1'b0;
      frame_q    <= '0;
    end else begin
      tgl_seen_q <= tgl_i;
      frame_q    <= {ctl_n, code};
      if (!locked_q) begin
        active_q <= 1'b0;
        phase_q  <= '0;
        if (lock_cnt_q == LC_W'(LOCK_CYCLES - 1)) locked_q <= 1'b1;
        else lock_cnt_q <= lock_cnt_q + 1'b1;
      end else if (start) begin
        hold_q   <= word_i;
        hdav_q   <= dav_i;
        phase_q  <= PH_W'(1 % NSLICE);
        active_q <= (NSLICE > 1);
      end else if (active_q) begin
        if (phase_q == PH_W'(NSLICE - 1)) begin
          phase_q  <= '0;
          active_q <= 1'b0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign frame_o  = frame_q;
  assign locked_o = locked_q;

  logic [CTL_W-1:0] ctl_q;
  assign ctl_q = frame_q[FRAME_W-1 -: CTL_W];

  p_reset_clear_r7: assert property (@(posedge clk_line)
    rst |=> (frame_q == '0 && !locked_q));

  p_lock_on_train_r4: assert property (@(posedge clk_line) disable iff (rst)
    $rose(locked_q) |-> (ctl_q == CTL_TRAIN && lock_cnt_q == LC_W'(LOCK_CYCLES - 1)));

  p_lock_holds_r4: assert property (@(posedge clk_line) disable iff (rst)
    locked_q |=> locked_q);

  p_next_chain_r2: assert property (@(posedge clk_line) disable iff (rst)
    (ctl_q == CTL_NEXT) |-> ($past(ctl_q) == CTL_FIRST || $past(ctl_q) == CTL_NEXT));

  p_data_locked_r6: assert property (@(posedge clk_line) disable iff (rst)
    (ctl_q == CTL_FIRST || ctl_q == CTL_NEXT) |-> locked_q);

  p_phase_range_r2: assert property (@(posedge clk_line) disable iff (rst)
    int'(phase_q) < NSLICE);
endmodule

// File: rtl/rdlink_channel.sv
module rdlink_channel
  import rdlink_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SLICE_W     = 8,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                       clk_word,
  input  logic                       clk_line,
  input  logic                       rst,
  input  logic [WORD_W-1:0]          word_i,
  input  logic                       dav_i,
  output logic [CTL_W+2*SLICE_W-1:0] frame_o,
  output logic                       locked_o
);
  logic [WORD_W-1:0] cap_word;
  logic              cap_dav;
  logic              cap_tgl;

  rdlink_word_capture #(.WORD_W(WORD_W)) u_cap (
    .clk_word (clk_word),
    .rst      (rst),
    .word_i   (word_i),
    .dav_i    (dav_i),
    .word_o   (cap_word),
    .dav_o    (cap_dav),
    .tgl_o    (cap_tgl)
  );

  rdlink_line_enc #(
    .WORD_W      (WORD_W),
    .SLICE_W     (SLICE_W),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_line (
    .clk_line (clk_line),
    .rst      (rst),
    .word_i   (cap_word),
    .dav_i    (cap_dav),
    .tgl_i    (cap_tgl),
    .frame_o  (frame_o),
    .locked_o (locked_o)
  );
endmodule

// File: rtl/rdlink_frame_enc.sv
module rdlink_frame_enc
  import rdlink_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SLICE_W     = 8,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                       clk_word,
  input  logic                       clk_line,
  input  logic                       daq_rst,
  input  logic [WORD_W-1:0]          daq_word,
  input  logic                       daq_dav,
  output logic [CTL_W+2*SLICE_W-1:0] daq_frame,
  output logic                       daq_locked,
  input  logic                       roi_rst,
  input  logic [WORD_W-1:0]          roi_word,
  input  logic                       roi_dav,
  output logic [CTL_W+2*SLICE_W-1:0] roi_frame,
  output logic                       roi_locked
);
  rdlink_channel #(
    .WORD_W (WORD_W), .SLICE_W (SLICE_W), .LOCK_CYCLES (LOCK_CYCLES)
  ) u_daq (
    .clk_word (clk_word),
    .clk_line (clk_line),
    .rst      (daq_rst),
    .word_i   (daq_word),
    .dav_i    (daq_dav),
    .frame_o  (daq_frame),
    .locked_o (daq_locked)
  );

  rdlink_channel #(
    .WORD_W (WORD_W), .SLICE_W (SLICE_W), .LOCK_CYCLES (LOCK_CYCLES)
  ) u_roi (
    .clk_word (clk_word),
    .clk_line (clk_line),
    .rst      (roi_rst),
    .word_i   (roi_word),
    .dav_i    (roi_dav),
    .frame_o  (roi_frame),
    .locked_o (roi_locked)
  );
endmodule

// File: tb/rdlink_frame_enc_tb.sv
module rdlink_frame_enc_tb;
  localparam int LOCK = 64;

  logic        clk_word, clk_line;
  logic        daq_rst, roi_rst;
  logic [23:0] daq_word, roi_word;
  logic        daq_dav, roi_dav;
  logic [19:0] daq_frame, roi_frame;
  logic        daq_locked, roi_locked;

  int checks = 0;
  int errors = 0;
  int edge_n = -1;
  int mcnt [2];
  logic [23:0] hw [2][4];
  logic        hd [2][4];
  logic [7:0]  b = 8'd0;

  rdlink_frame_enc u_dut (
    .clk_word (clk_word), .clk_line (clk_line),
    .daq_rst (daq_rst), .daq_word (daq_word), .daq_dav (daq_dav),
    .daq_frame (daq_frame), .daq_locked (daq_locked),
    .roi_rst (roi_rst), .roi_word (roi_word), .roi_dav (roi_dav),
    .roi_frame (roi_frame), .roi_locked (roi_locked)
  );

  // 50 MHz line clock; word clock rises on every third line edge
  initial begin
    clk_line = 1'b0;
    clk_word = 1'b0;
    forever begin
      #10;
      edge_n++;
      clk_line = 1'b1;
      if (edge_n % 3 == 0) begin
        clk_word = 1'b1;
        hw[0][(edge_n/3)%4] = daq_word;
        hd[0][(edge_n/3)%4] = daq_dav;
        hw[1][(edge_n/3)%4] = roi_word;
        hd[1][(edge_n/3)%4] = roi_dav;
      end
      #10;
      clk_line = 1'b0;
      if (edge_n % 3 == 1) clk_word = 1'b0;
    end
  end

  function automatic logic [15:0] bal(input logic [7:0] s);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i+1] = s[i];
      r[2*i]   = ~s[i];
    end
    return r;
  endfunction

  // reference built from the requirements, sampled at the falling edge
  logic        rv, lk, el;
  logic [19:0] fr, ef;
  logic [7:0]  sl;
  int          k, n0, idx;
  string       tag;
  always @(negedge clk_line) begin
    if (edge_n >= 0) begin
      for (int c = 0; c < 2; c++) begin
        rv = (c == 0) ? daq_rst : roi_rst;
        fr = (c == 0) ? daq_frame : roi_frame;
        lk = (c == 0) ? daq_locked : roi_locked;
        if (rv) mcnt[c] = 0; else mcnt[c]++;
        if (rv) begin
          ef = '0; el = 1'b0; tag = "R7";
        end else if (mcnt[c] <= LOCK) begin
          ef = {4'b1100, 16'h55AA}; el = (mcnt[c] == LOCK); tag = "R4";
        end else begin
          el  = 1'b1;
          k   = (edge_n - 1) % 3;
          n0  = edge_n - k - 1;
          idx = (n0 / 3) % 4;
          if (mcnt[c] - k <= LOCK) begin
            ef = {4'b0101, 16'h5555}; tag = "R6";
          end else if (!hd[c][idx]) begin
            ef = {4'b0101, 16'h5555}; tag = "R3 R5";
          end else begin
            sl  = hw[c][idx][23-8*k -: 8];
            ef  = {(k == 0) ? 4'b1010 : 4'b0011, bal(sl)};
            tag = "R1 R2 R5";
          end
        end
        if (c == 0 && roi_rst && !rv) tag = {tag, " R8"};
        checks++;
        if (fr !== ef) begin
          errors++;
          $display("FAIL %s ch%0d edge %0d frame actual %h expected %h", tag, c, edge_n, fr, ef);
        end
        checks++;
        if (lk !== el) begin
          errors++;
          $display("FAIL %s ch%0d edge %0d locked actual %b expected %b", tag, c, edge_n, lk, el);
        end
      end
    end
  end

  // inputs move every line cycle; the chosen word is set just before a word edge
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_line);
      #2;
      if (edge_n % 3 == 2) begin
        daq_word = {b, b ^ 8'h5A, ~b};
        daq_dav  = (b % 3) != 0;
        roi_word = {~b, b, b + 8'd1};
        roi_dav  = b[1];
        b        = b + 8'd1;
      end else begin
        daq_word = daq_word ^ 24'hFFFFFF;
        daq_dav  = ~daq_dav;
        roi_word = roi_word ^ 24'hA5A5A5;
        roi_dav  = ~roi_dav;
      end
    end
  endtask

  initial begin
    daq_rst = 1'b1; roi_rst = 1'b1;
    daq_word = '0; roi_word = '0; daq_dav = 1'b0; roi_dav = 1'b0;
    mcnt[0] = 0; mcnt[1] = 0;
    run(12);
    daq_rst = 1'b0;
    run(1);
    roi_rst = 1'b0;
    run(790);
    for (int off = 0; off < 3; off++) begin
      while (edge_n % 3 != off) run(1);
      roi_rst = 1'b1;
      run(4);
      roi_rst = 1'b0;
      run(90);
    end
    daq_rst = 1'b1;
    run(5);
    daq_rst = 1'b0;
    run(90);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule